// File: doc/BRIEF.md
# Extended Real-Mode Effective-Address Generator

This block forms the operand address of a memory-reference instruction when the processor runs in the extended real addressing mode. It accepts one command at a time. A command carries the instruction's indirect flag, its index-register selector, its 17-bit reference address, the 32-bit value of the selected index register and a 2-bit operand-size code. Two status-word mode bits decide whether the extended mode applies. In extended mode the 17-bit reference grows to a 20-bit word address. An indirect word may first replace it, and an index value aligned to the operand size may then be added. The result is a 22-bit byte-granular address. It is presented as a 20-bit word address plus a 2-bit fine part.

Commands enter on a valid/ready pair. `cmd_ready` is high only while the block is idle. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. The command fields need only be valid in that cycle. Holding `cmd_valid` high while `cmd_ready` is low is allowed, and the command then waits. For an indirect fetch the block raises `mem_req` and holds `mem_addr` until `mem_ack` arrives. `mem_rdata` is sampled in the `mem_ack` cycle. The memory may stall for any number of cycles. `done` is a one-cycle strobe. The address outputs stay valid from that strobe until the next strobe.

Top module: `ext_ea_gen`

## Requirements
- R1: After synchronous reset, `cmd_ready` is 1 and both `done` and `mem_req` are 0.
- R2: When the mode is not extended (`st_map`=1 or `st_ext`=0), the result word address is the reference address zero-extended and the fine part is 0. In this mode the index value and the indirect flag have no effect, and no memory request is made.
- R3: In extended mode, with the selector 0 and the indirect flag 0, the three added high bits of the word address are zero and the fine part is 0.
- R4: Byte size (code 0): byte address = (base·4 + index) mod 2^22, where base is the 20-bit word base.
- R5: Halfword size (code 1): byte address = 2·((base·2 + index) mod 2^21). Fine bit 0 is therefore 0.
- R6: Word size (code 2): word address = (base + index) mod 2^20, and fine = 0. A carry out of the 17 reference bits lands in the three high bits.
- R7: Doubleword size (code 3): byte address = 8·((floor(base/2) + index) mod 2^19). Fine = 0 and word-address bit 0 is 0.
- R8: A selector value of 0 means no indexing, so the index value is ignored. Any nonzero selector enables indexing.
- R9: In extended mode with the indirect flag set, the block raises `mem_req` with `mem_addr` equal to the reference address. It holds both steady until `mem_ack`, and `mem_rdata` (20 bits) then becomes the base. Exactly one request is made per command.
- R10: With indirection and indexing both set, indexing and size alignment apply to the base fetched from memory.
- R11: The index takes part in the add at its full 32-bit width. The sum wraps, so an all-ones index acts as −1.
- R12: `done` lasts exactly one cycle per command, and `cmd_ready` is 0 while a command is in progress, `done` included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| st_map | input | 1 | Status mode bit; must be 0 for extended mode |
| st_ext | input | 1 | Status mode bit; must be 1 for extended mode |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_ind | input | 1 | Indirect flag |
| cmd_sel | input | 3 | Index selector, 0 = none |
| cmd_ref | input | 17 | Reference word address |
| cmd_idx | input | 32 | Selected index register value |
| cmd_size | input | 2 | Operand size: 0 byte, 1 halfword, 2 word, 3 doubleword |
| mem_req | output | 1 | Indirect word request |
| mem_addr | output | 20 | Indirect word address |
| mem_ack | input | 1 | Memory response strobe |
| mem_rdata | input | 20 | Low bits of the indirect word |
| done | output | 1 | Result strobe, one cycle |
| ea_word | output | 20 | Result word address |
| ea_fine | output | 2 | Byte offset within the word |

## Verification
Each operand size is tried with small indexes and with indexes that carry across the 17-bit reference boundary. Each size produces a different sum for the same operands, so a swapped shift or a wrong alignment width shows up. All-ones and large indexes show whether the add wraps at the size's own width and whether the index is used at its full width. Zero-selector and non-extended commands carry nonzero index values and a set indirect flag, so any leak of those fields into the result changes it. Indirect commands run against memory latencies from zero to several cycles, with and without an index, which tests the request hold, the replaced base and the order of fetch and add.

// File: rtl/ext_ea_pkg.sv
package ext_ea_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } opsize_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CALC,
    ST_DONE
  } eag_state_e;
endpackage

// File: rtl/ext_ea_align.sv
module ext_ea_align
  import ext_ea_pkg::*;
#(
  parameter int WADDR_W = 20,
  parameter int IDX_W   = 32
) (
  input  logic [WADDR_W-1:0] base,
  input  logic [IDX_W-1:0]   idx,
  input  logic               use_idx,
  input  opsize_e            size,
  output logic [WADDR_W+1:0] byte_addr
);
  localparam int BW = WADDR_W + 2;

  logic [IDX_W-1:0] idx_eff;
  logic [BW-1:0]    cand [4];

  assign idx_eff = use_idx ? idx : '0;

  // one candidate per operand size; arithmetic width shrinks with size
  for (genvar g = 0; g < 4; g++) begin : g_sz
    localparam int AW = BW - g;
    logic [AW-1:0] base_al;
    logic [AW-1:0] sum;
    if (g < 2) begin : g_left
      assign base_al = {base, {(2 - g){1'b0}}};
    end else if (g == 2) begin : g_none
      assign base_al = base;
    end else begin : g_right
      assign base_al = base[WADDR_W-1:1];
    end
    // full-width add, truncated at the size's own field width
    assign sum     = AW'(IDX_W'(base_al) + idx_eff);
    assign cand[g] = BW'(sum) << g;
  end

  assign byte_addr = cand[size];
endmodule

// File: rtl/ext_ea_ctrl.sv
module ext_ea_ctrl
  import ext_ea_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmd_valid,
  input  logic need_fetch,
  input  logic mem_ack,
  output logic cmd_ready,
  output logic accept,
  output logic mem_req,
  output logic fetch_done,
  output logic calc_en,
  output logic done
);
  eag_state_e state_q, state_d;

  assign cmd_ready  = (state_q == ST_IDLE);
  assign accept     = cmd_ready && cmd_valid;
  assign mem_req    = (state_q == ST_FETCH);
  assign fetch_done = mem_req && mem_ack;
  assign calc_en    = (state_q == ST_CALC);
  assign done       = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = need_fetch ? ST_FETCH : ST_CALC;
      ST_FETCH: if (mem_ack) state_d = ST_CALC;
      ST_CALC:  state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/ext_ea_gen.sv
module ext_ea_gen
  import ext_ea_pkg::*;
#(
  parameter int REF_W   = 17,
  parameter int WADDR_W = 20,
  parameter int IDX_W   = 32,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               st_map,
  input  logic               st_ext,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_ind,
  input  logic [SEL_W-1:0]   cmd_sel,
  input  logic [REF_W-1:0]   cmd_ref,
  input  logic [IDX_W-1:0]   cmd_idx,
  input  logic [1:0]         cmd_size,
  output logic               mem_req,
  output logic [WADDR_W-1:0] mem_addr,
  input  logic               mem_ack,
  input  logic [WADDR_W-1:0] mem_rdata,
  output logic               done,
  output logic [WADDR_W-1:0] ea_word,
  output logic [1:0]         ea_fine
);
  localparam int BW = WADDR_W + 2;

  logic               ext_mode;
  logic               need_fetch;
  logic               accept, fetch_done, calc_en;
  logic               active_q, use_idx_q;
  opsize_e            size_q;
  logic [IDX_W-1:0]   idx_q;
  logic [WADDR_W-1:0] base_q;
  logic [BW-1:0]      aligned;
  logic [BW-1:0]      ea_q;

  assign ext_mode   = !st_map && st_ext;
  assign need_fetch = ext_mode && cmd_ind;

  ext_ea_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .need_fetch (need_fetch),
    .mem_ack    (mem_ack),
    .cmd_ready  (cmd_ready),
    .accept     (accept),
    .mem_req    (mem_req),
    .fetch_done (fetch_done),
    .calc_en    (calc_en),
    .done       (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      use_idx_q <= 1'b0;
      size_q    <= SZ_WORD;
      idx_q     <= '0;
      base_q    <= '0;
    end else if (accept) begin
      active_q  <= ext_mode;
      use_idx_q <= ext_mode && (cmd_sel != '0);
      size_q    <= opsize_e'(cmd_size);
      idx_q     <= cmd_idx;
      base_q    <= WADDR_W'(cmd_ref);
    end else if (fetch_done) begin
      base_q    <= mem_rdata;
    end
  end

  ext_ea_align #(
    .WADDR_W (WADDR_W),
    .IDX_W   (IDX_W)
  ) u_align (
    .base      (base_q),
    .idx       (idx_q),
    .use_idx   (use_idx_q),
    .size      (size_q),
    .byte_addr (aligned)
  );

  always_ff @(posedge clk) begin
    if (rst)          ea_q <= '0;
    else if (calc_en) ea_q <= active_q ? aligned : {base_q, 2'b00};
  end

  assign mem_addr = base_q;
  assign ea_word  = ea_q[BW-1:2];
  assign ea_fine  = ea_q[1:0];
endmodule

// File: rtl/ext_ea_gen_chk.sv
module ext_ea_gen_chk
  import ext_ea_pkg::*;
#(
  parameter int WADDR_W = 20
) (
  input logic               clk,
  input logic               rst,
  input logic               st_map,
  input logic               st_ext,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic               mem_req,
  input logic               mem_ack,
  input logic [WADDR_W-1:0] mem_addr,
  input logic               done,
  input logic [1:0]         ea_fine,
  input logic [WADDR_W-1:0] ea_word,
  input logic               active_q,
  input opsize_e            size_q
);
  // R9: request and address held until acknowledged
  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R12: strobe lasts one cycle
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12: no new command while busy
  p_busy_r12: assert property (@(posedge clk) disable iff (rst)
    (mem_req || done) |-> !cmd_ready);

  // R2: no fetch outside extended mode
  p_no_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && !(!st_map && st_ext)) |=> !mem_req);

  // R6, R7: word and doubleword results carry no fine part
  p_fine_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (done && size_q[1]) |-> (ea_fine == 2'b00));

  // R7: doubleword address is even in words
  p_dbl_even_r7: assert property (@(posedge clk) disable iff (rst)
    (done && active_q && size_q == SZ_DBL) |-> !ea_word[0]);

  // R5: halfword result has an even byte offset
  p_half_even_r5: assert property (@(posedge clk) disable iff (rst)
    (done && active_q && size_q == SZ_HALF) |-> !ea_fine[0]);
endmodule

bind ext_ea_gen ext_ea_gen_chk #(.WADDR_W(WADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .st_map    (st_map),
  .st_ext    (st_ext),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .done      (done),
  .ea_fine   (ea_fine),
  .ea_word   (ea_word),
  .active_q  (active_q),
  .size_q    (size_q)
);

// File: tb/test_ext_ea_gen.sv
module test_ext_ea_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_map = 1'b0, st_ext = 1'b1;
  logic        cmd_valid = 1'b0, cmd_ind = 1'b0;
  logic [2:0]  cmd_sel = '0;
  logic [16:0] cmd_ref = '0;
  logic [31:0] cmd_idx = '0;
  logic [1:0]  cmd_size = '0;
  logic        mem_ack = 1'b0;
  logic [19:0] mem_rdata = '0;
  logic        cmd_ready, mem_req, done;
  logic [19:0] mem_addr, ea_word;
  logic [1:0]  ea_fine;

  int total = 0, bad = 0;
  int req_count = 0, mem_lat = 0, items_done = 0, items_sent = 0;

  typedef struct {
    logic [21:0] addr;
    int          reqs;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_ea_gen i_ext_ea_gen (
    .clk(clk), .rst(rst), .st_map(st_map), .st_ext(st_ext),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_ind(cmd_ind),
    .cmd_sel(cmd_sel), .cmd_ref(cmd_ref), .cmd_idx(cmd_idx),
    .cmd_size(cmd_size), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done),
    .ea_word(ea_word), .ea_fine(ea_fine)
  );

  function automatic logic [19:0] mem_word(logic [19:0] a);
    return a ^ 20'h9B6D3;
  endfunction

  function automatic logic [21:0] model(logic act, logic ind, logic [2:0] sel,
                                        logic [16:0] rf, logic [31:0] idx,
                                        logic [1:0] sz);
    logic [19:0] base;
    logic [31:0] ix, s;
    if (!act) return {3'b000, rf, 2'b00};
    base = ind ? mem_word({3'b000, rf}) : {3'b000, rf};
    ix   = (sel != 0) ? idx : 32'd0;
    case (sz)
      2'd0:    begin s = {10'd0, base, 2'b00} + ix; return s[21:0]; end
      2'd1:    begin s = {11'd0, base, 1'b0} + ix;  return {s[20:0], 1'b0}; end
      2'd2:    begin s = {12'd0, base} + ix;        return {s[19:0], 2'b00}; end
      default: begin s = {13'd0, base[19:1]} + ix;  return {s[18:0], 3'b000}; end
    endcase
  endfunction

  function automatic void check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  task automatic send(logic m, logic e, logic ind, logic [2:0] sel,
                      logic [16:0] rf, logic [31:0] idx, logic [1:0] sz,
                      int lat, string tag);
    exp_t x;
    logic act;
    act = !m && e;
    while (!cmd_ready) @(negedge clk);
    st_map = m; st_ext = e; cmd_ind = ind; cmd_sel = sel;
    cmd_ref = rf; cmd_idx = idx; cmd_size = sz; mem_lat = lat;
    x.addr = model(act, ind, sel, rf, idx, sz);
    x.reqs = req_count + ((act && ind) ? 1 : 0);
    x.tag  = tag;
    q.push_back(x);
    items_sent++;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_idx = 32'hDEAD_BEEF; cmd_ref = 17'h15555;
    while (items_done < items_sent) @(negedge clk);
  endtask

  // memory responder; checks request hold and address (R9)
  initial begin
    logic [19:0] a;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        a = mem_addr;
        req_count++;
        check(a[19:17] == 3'b000, "R9 fetch address high bits", {12'd0, a}, 32'd0);
        for (int i = 0; i < mem_lat; i++) begin
          @(negedge clk);
          check(mem_req && mem_addr == a, "R9 request held", {11'd0, mem_req, mem_addr}, {12'd1, a});
        end
        mem_rdata = mem_word(a);
        mem_ack   = 1'b1;
        @(negedge clk);
        mem_ack   = 1'b0;
        mem_rdata = 20'hFFFFF;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    exp_t x;
    logic prev_done = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (done && prev_done) check(0, "R12 done longer than one cycle", 1, 0);
        if (done) begin
          check(!cmd_ready, "R12 ready low during done", {31'd0, cmd_ready}, 0);
          if (q.size() == 0) check(0, "R12 unexpected done", 1, 0);
          else begin
            x = q.pop_front();
            check({ea_word, ea_fine} == x.addr, x.tag, {10'd0, ea_word, ea_fine}, {10'd0, x.addr});
            check(req_count == x.reqs, {x.tag, " request count R9"}, req_count, x.reqs);
          end
          items_done++;
        end
        prev_done = done;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R12 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cmd_ready && !done && !mem_req, "R1 reset state",
          {29'd0, cmd_ready, done, mem_req}, 32'h4);

    // R2: mode off; index, selector and indirect flag must not matter
    send(1, 1, 1, 3'd5, 17'h0ABCD, 32'h0007_0003, 2'd0, 0, "R2 map bit set");
    send(0, 0, 1, 3'd2, 17'h1FFFF, 32'hFFFF_FFFF, 2'd3, 0, "R2 ext bit clear");
    // R3: no index, no indirection
    send(0, 1, 0, 3'd0, 17'h1FFFF, 32'h0, 2'd0, 0, "R3 plain byte");
    send(0, 1, 0, 3'd0, 17'h10001, 32'h0, 2'd3, 0, "R3 plain dbl");
    // R8: selector zero ignores index
    send(0, 1, 0, 3'd0, 17'h00123, 32'hFFFF_FFFF, 2'd2, 0, "R8 sel zero");
    send(0, 1, 0, 3'd7, 17'h00123, 32'h0000_0010, 2'd2, 0, "R8 sel seven");
    // R4..R7 alignments
    send(0, 1, 0, 3'd1, 17'h12345, 32'h7, 2'd0, 0, "R4 byte");
    send(0, 1, 0, 3'd1, 17'h00010, 32'h3, 2'd1, 0, "R5 half");
    send(0, 1, 0, 3'd1, 17'h1FFFF, 32'h1, 2'd2, 0, "R6 word carry");
    send(0, 1, 0, 3'd1, 17'h1FFFF, 32'h0006_0000, 2'd2, 0, "R6 word high");
    send(0, 1, 0, 3'd1, 17'h00101, 32'h2, 2'd3, 0, "R7 dbl");
    send(0, 1, 0, 3'd1, 17'h1FFFF, 32'h0004_0001, 2'd3, 0, "R7 dbl carry");
    // R11 wrap and full-width index
    send(0, 1, 0, 3'd3, 17'h00000, 32'hFFFF_FFFF, 2'd2, 0, "R11 word wrap");
    send(0, 1, 0, 3'd3, 17'h00001, 32'hFFFF_FFFF, 2'd0, 0, "R11 byte minus one");
    send(0, 1, 0, 3'd3, 17'h00040, 32'h8030_0000, 2'd0, 0, "R11 byte big index");
    // R9 / R10 indirection with various latencies
    send(0, 1, 1, 3'd0, 17'h0F00F, 32'h5, 2'd2, 0, "R9 indirect lat0");
    send(0, 1, 1, 3'd0, 17'h1ABCD, 32'h5, 2'd0, 3, "R9 indirect lat3");
    send(0, 1, 1, 3'd4, 17'h00077, 32'h0000_1235, 2'd1, 1, "R10 indirect half");
    send(0, 1, 1, 3'd6, 17'h1FFFF, 32'h0001_0003, 2'd3, 5, "R10 indirect dbl");
    send(0, 1, 1, 3'd2, 17'h02468, 32'hFFFF_FFF0, 2'd2, 2, "R10 indirect word");

    lf = 32'hACE1_2345;
    for (int k = 0; k < 40; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      send(lf[5] & lf[6], lf[7] | lf[8], lf[9], lf[12:10], lf[28:12],
           {lf[3:0], lf[31:4]} >> lf[4:0], lf[14:13], k % 4, "R4 R10 mixed");
    end

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R12 all results seen", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule